// File: doc/BRIEF.md
# Banked Multi-Requester Data RAM Controller

This block is the front end of an on-chip data RAM shared by three requesters: two CPU load/store ports (side A and side B) and a DMA port. The RAM is divided into two blocks. Each block is built from four 16-bit banks, interleaved by halfword. Every cycle the controller decodes each request into a block, a bank and a row. It serves at the same time all requests that touch disjoint banks. When two requests meet on a bank, it picks a winner by fixed priority and stalls the others.

Accesses may be byte, halfword or 32-bit word. A word covers two adjacent banks, so conflicts are judged per 16-bit bank and not per port. Read data comes back on the cycle after the grant. Requests that are out of range or misaligned are answered with an error pulse and do not touch the array. The block span is set by `BLK_LG`, the log2 of a block's size in bytes. The default of 10 keeps the array small. A value of 16 gives two 64 KB blocks at 0x8000_0000 and 0x8001_0000.

Top module: `dram_bank_ctrl`

## Requirements
- R1: A request is in range when its address lies within 2·2^BLK_LG bytes from BASE. Address bit BLK_LG selects block 1 (set) or block 0 (clear). Bits [BLK_LG-1:3] select the row.
- R2: The bank inside a block is address bits [2:1]. Byte offsets 0–1, 2–3, 4–5 and 6–7 of each 8-byte group fall in banks 0, 1, 2 and 3.
- R3: The size code is 0 for a byte, 1 for a halfword and 2 for a word. A word covers two banks and is little-endian: the lowest address holds bits [7:0]. A byte or halfword covers one bank.
- R4: Requests whose bank sets are disjoint are all served in the same cycle, with no stall.
- R5: On a shared bank, priority goes A, then B, then DMA. A never stalls. A loser sees its stall output high in that cycle and its access does not happen.
- R6: Banks with the same number in different blocks are distinct. Such requests never conflict.
- R7: A served read raises rvalid on the next cycle, with data zero-extended for byte and halfword reads. rdata holds its value until the next served read.
- R8: A write changes only the bytes it addresses. The other bytes of the touched banks keep their values.
- R9: A request that is out of range, misaligned (odd halfword, word not on 4 bytes) or has size code 3 touches no bank and never stalls. It raises err on the next cycle, with rvalid low.
- R10: While reset is held and after it, rvalid, err and rdata are zero until the first served request.
- R11: Only served requests block lower ones. DMA proceeds if its only overlap is with a stalled B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Side A request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_size | input | 2 | Side A size code |
| a_addr | input | 32 | Side A byte address |
| a_wdata | input | 32 | Side A store data |
| a_stall | output | 1 | Side A not served this cycle |
| a_rvalid | output | 1 | Side A read data valid |
| a_err | output | 1 | Side A rejected request |
| a_rdata | output | 32 | Side A load data |
| b_req | input | 1 | Side B request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_size | input | 2 | Side B size code |
| b_addr | input | 32 | Side B byte address |
| b_wdata | input | 32 | Side B store data |
| b_stall | output | 1 | Side B not served this cycle |
| b_rvalid | output | 1 | Side B read data valid |
| b_err | output | 1 | Side B rejected request |
| b_rdata | output | 32 | Side B load data |
| d_req | input | 1 | DMA request |
| d_we | input | 1 | DMA write (1) or read (0) |
| d_size | input | 2 | DMA size code |
| d_addr | input | 32 | DMA byte address |
| d_wdata | input | 32 | DMA store data |
| d_stall | output | 1 | DMA not served this cycle |
| d_rvalid | output | 1 | DMA read data valid |
| d_err | output | 1 | DMA rejected request |
| d_rdata | output | 32 | DMA load data |

## Verification
In one cycle the controller can serve one requester on a bank while it stalls a second requester on that same bank. In the same cycle a third request can pass through to a bank that is free, or hit the stalled requester's bank, which is not held. Directed cycles set up these cases on purpose: a word overlapping two halfwords, the same bank number in both blocks, and three-way collisions. Random traffic over a 32-byte window in each block then makes such overlaps frequent. A behavioural model keeps a byte array and a set of claimed banks, and on every cycle it predicts the stalls, the errors and the returned data.

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl #(
  parameter int          BLK_LG = 10,
  parameter logic [31:0] BASE   = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_req,
  input  logic        a_we,
  input  logic [1:0]  a_size,
  input  logic [31:0] a_addr,
  input  logic [31:0] a_wdata,
  output logic        a_stall,
  output logic        a_rvalid,
  output logic        a_err,
  output logic [31:0] a_rdata,
  input  logic        b_req,
  input  logic        b_we,
  input  logic [1:0]  b_size,
  input  logic [31:0] b_addr,
  input  logic [31:0] b_wdata,
  output logic        b_stall,
  output logic        b_rvalid,
  output logic        b_err,
  output logic [31:0] b_rdata,
  input  logic        d_req,
  input  logic        d_we,
  input  logic [1:0]  d_size,
  input  logic [31:0] d_addr,
  input  logic [31:0] d_wdata,
  output logic        d_stall,
  output logic        d_rvalid,
  output logic        d_err,
  output logic [31:0] d_rdata
);
  localparam int NR   = 3;
  localparam int NB   = 8;
  localparam int RW   = BLK_LG - 3;
  localparam int ROWS = 1 << RW;

  logic [NR-1:0]        req, we, ok, live, gnt, stall;
  logic [1:0]           size  [NR];
  logic [31:0]          addr  [NR];
  logic [31:0]          wdata [NR];
  logic [31:0]          asm_rd[NR];
  logic [NB-1:0]        mask  [NR];
  logic [2:0]           bidx  [NR];
  logic [NB-1:0][15:0]  rd_bank;
  logic [NR-1:0]        rvalid_q, err_q;
  logic [31:0]          rdata_q [NR];
  logic [NB-1:0]        used_a, used_ab;

  assign req = {d_req, b_req, a_req};
  assign we  = {d_we,  b_we,  a_we};
  assign size[0]  = a_size;  assign size[1]  = b_size;  assign size[2]  = d_size;
  assign addr[0]  = a_addr;  assign addr[1]  = b_addr;  assign addr[2]  = d_addr;
  assign wdata[0] = a_wdata; assign wdata[1] = b_wdata; assign wdata[2] = d_wdata;

  generate
    for (genvar r = 0; r < NR; r++) begin : g_dec
      logic        in_rng, aligned;
      logic [15:0] lo, hi;
      assign in_rng  = addr[r][31:BLK_LG+1] == BASE[31:BLK_LG+1];
      assign aligned = (size[r] == 2'd0) ||
                       (size[r] == 2'd1 && !addr[r][0]) ||
                       (size[r] == 2'd2 && addr[r][1:0] == 2'b00);
      assign ok[r]   = in_rng && aligned;
      assign live[r] = req[r] && ok[r];
      assign bidx[r] = {addr[r][BLK_LG], addr[r][2:1]};
      assign mask[r] = (size[r] == 2'd2 ? 8'b0000_0011 : 8'b0000_0001) << bidx[r];
      assign lo = rd_bank[bidx[r]];
      assign hi = rd_bank[bidx[r] | 3'd1];
      always_comb begin
        case (size[r])
          2'd0:    asm_rd[r] = {24'd0, addr[r][0] ? lo[15:8] : lo[7:0]};
          2'd1:    asm_rd[r] = {16'd0, lo};
          default: asm_rd[r] = {hi, lo};
        endcase
      end
    end
  endgenerate

  assign gnt[0]  = live[0];
  assign used_a  = gnt[0] ? mask[0] : '0;
  assign gnt[1]  = live[1] && ((mask[1] & used_a) == '0);
  assign used_ab = used_a | (gnt[1] ? mask[1] : '0);
  assign gnt[2]  = live[2] && ((mask[2] & used_ab) == '0);
  assign stall   = live & ~gnt;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_bank
      logic [15:0]   m [ROWS];
      logic          wen;
      logic [1:0]    be;
      logic [15:0]   wd;
      logic [RW-1:0] row;
      logic [NR-1:0] own;
      always_comb begin
        wen = 1'b0; be = 2'b00; wd = '0; row = '0; own = '0;
        for (int r = 0; r < NR; r++) begin
          if (gnt[r] && mask[r][k]) begin
            own[r] = 1'b1;
            row    = addr[r][BLK_LG-1:3];
            wen    = we[r];
            case (size[r])
              2'd0: begin
                be = addr[r][0] ? 2'b10 : 2'b01;
                wd = {2{wdata[r][7:0]}};
              end
              2'd1: begin
                be = 2'b11;
                wd = wdata[r][15:0];
              end
              default: begin
                be = 2'b11;
                wd = (k % 2 == 1) ? wdata[r][31:16] : wdata[r][15:0];
              end
            endcase
          end
        end
      end
      always_ff @(posedge clk) begin
        if (wen) begin
          if (be[0]) m[row][7:0]  <= wd[7:0];
          if (be[1]) m[row][15:8] <= wd[15:8];
        end
      end
      assign rd_bank[k] = m[row];

      p_bank_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= '0;
      err_q    <= '0;
      for (int r = 0; r < NR; r++) rdata_q[r] <= '0;
    end else begin
      rvalid_q <= gnt & ~we;
      err_q    <= req & ~ok;
      for (int r = 0; r < NR; r++)
        if (gnt[r] && !we[r]) rdata_q[r] <= asm_rd[r];
    end
  end

  assign a_stall = stall[0];  assign b_stall = stall[1];  assign d_stall = stall[2];
  assign a_rvalid = rvalid_q[0]; assign b_rvalid = rvalid_q[1]; assign d_rvalid = rvalid_q[2];
  assign a_err = err_q[0];    assign b_err = err_q[1];    assign d_err = err_q[2];
  assign a_rdata = rdata_q[0]; assign b_rdata = rdata_q[1]; assign d_rdata = rdata_q[2];

  p_a_never_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !a_stall);
  p_b_stall_needs_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    b_stall |-> a_req);
  p_d_stall_needs_winner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    d_stall |-> (a_req || (b_req && !b_stall)));
  p_read_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !b_we && ok[1] && !b_stall) |=> b_rvalid);
  p_bad_req_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !ok[2]) |=> (d_err && !d_rvalid));
  p_bad_req_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !ok[0]) |-> !a_stall);
endmodule

// File: tb/test_dram_bank_ctrl.sv
module test_dram_bank_ctrl;
  localparam int          CLK_P  = 10;
  localparam int          BLK_LG = 10;
  localparam logic [31:0] BASE   = 32'h8000_0000;
  localparam int          SPAN   = 2 << BLK_LG;
  localparam logic [31:0] B0     = BASE;
  localparam logic [31:0] B1     = BASE + (1 << BLK_LG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic        rq [3], w [3];
  logic [1:0]  sz [3];
  logic [31:0] ad [3], wd [3];
  logic        a_stall, a_rvalid, a_err, b_stall, b_rvalid, b_err, d_stall, d_rvalid, d_err;
  logic [31:0] a_rdata, b_rdata, d_rdata;
  logic        stl [3], rv [3], er [3];
  logic [31:0] rd [3];

  dram_bank_ctrl #(.BLK_LG(BLK_LG), .BASE(BASE)) i_dram_bank_ctrl (
    .clk(clk), .rst_n(rst_n),
    .a_req(rq[0]), .a_we(w[0]), .a_size(sz[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
    .a_stall(a_stall), .a_rvalid(a_rvalid), .a_err(a_err), .a_rdata(a_rdata),
    .b_req(rq[1]), .b_we(w[1]), .b_size(sz[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
    .b_stall(b_stall), .b_rvalid(b_rvalid), .b_err(b_err), .b_rdata(b_rdata),
    .d_req(rq[2]), .d_we(w[2]), .d_size(sz[2]), .d_addr(ad[2]), .d_wdata(wd[2]),
    .d_stall(d_stall), .d_rvalid(d_rvalid), .d_err(d_err), .d_rdata(d_rdata));

  assign stl[0] = a_stall;  assign stl[1] = b_stall;  assign stl[2] = d_stall;
  assign rv[0]  = a_rvalid; assign rv[1]  = b_rvalid; assign rv[2]  = d_rvalid;
  assign er[0]  = a_err;    assign er[1]  = b_err;    assign er[2]  = d_err;
  assign rd[0]  = a_rdata;  assign rd[1]  = b_rdata;  assign rd[2]  = d_rdata;

  always #(CLK_P/2) clk = ~clk;

  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R10";
  byte unsigned mdl [SPAN];
  logic [31:0]  e_rd [3];
  bit           e_rv [3], e_er [3];

  function automatic void chk(string t, string what, int r, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s port%0d actual=%h expected=%h", t, what, r, got, exp);
    end
  endfunction

  task automatic drv(int r, bit q, bit wr, int s, logic [31:0] a, logic [31:0] d);
    rq[r] = q; w[r] = wr; sz[r] = 2'(s); ad[r] = a; wd[r] = d;
  endtask

  task automatic idle();
    for (int r = 0; r < 3; r++) drv(r, 0, 0, 0, BASE, 0);
  endtask

  task automatic step();
    int taken;
    bit e_st [3];
    bit g [3];
    longint o [3];
    int nb [3];
    taken = 0;
    for (int r = 0; r < 3; r++) begin
      bit okr;
      int bm;
      o[r]  = longint'(ad[r]) - longint'(BASE);
      nb[r] = 1 << sz[r];
      okr = (o[r] >= 0) && (o[r] < SPAN) &&
            (sz[r] == 0 || (sz[r] == 1 && o[r] % 2 == 0) || (sz[r] == 2 && o[r] % 4 == 0));
      bm = 0;
      if (okr) for (int i = 0; i < nb[r]; i++) begin
        longint p = o[r] + i;
        bm |= 1 << (int'(p >> BLK_LG) * 4 + int'((p >> 1) & 3));
      end
      g[r] = 0; e_st[r] = 0;
      if (rq[r] && okr) begin
        if ((bm & taken) == 0) begin g[r] = 1; taken |= bm; end
        else e_st[r] = 1;
      end
      e_er[r] = rq[r] && !okr;
      e_rv[r] = g[r] && !w[r];
      if (e_rv[r]) begin
        logic [31:0] v = 0;
        for (int i = 0; i < nb[r]; i++) v |= 32'(mdl[o[r] + i]) << (8 * i);
        e_rd[r] = v;
      end
    end
    for (int r = 0; r < 3; r++)
      if (g[r] && w[r])
        for (int i = 0; i < nb[r]; i++) mdl[o[r] + i] = wd[r][8*i +: 8];
    #1;
    for (int r = 0; r < 3; r++) chk(tag, "stall", r, 32'(stl[r]), 32'(e_st[r]));
    @(posedge clk); #1;
    for (int r = 0; r < 3; r++) begin
      chk(tag, "rvalid", r, 32'(rv[r]), 32'(e_rv[r]));
      chk(tag, "err", r, 32'(er[r]), 32'(e_er[r]));
      chk(tag, "rdata", r, rd[r], e_rd[r]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    for (int r = 0; r < 3; r++) begin e_rd[r] = 0; e_rv[r] = 0; e_er[r] = 0; end
    for (int i = 0; i < SPAN; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      chk("R10", "rvalid", r, 32'(rv[r]), 0);
      chk("R10", "err", r, 32'(er[r]), 0);
      chk("R10", "rdata", r, rd[r], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R8";
    for (int i = 0; i < SPAN; i += 4) begin drv(0, 1, 1, 2, BASE + 32'(i), 0); step(); end

    tag = "R1";
    idle(); drv(0, 1, 1, 2, B1 + 8, 32'h1122_3344); step();
    idle(); drv(0, 1, 0, 2, B0 + 8, 0); drv(1, 1, 0, 2, B1 + 8, 0); step();
    idle(); drv(2, 1, 1, 2, B1 + 1020, 32'hDEAD_BEEF); step();
    idle(); drv(1, 1, 0, 2, B1 + 1020, 0); drv(0, 1, 0, 2, BASE + SPAN, 0); step();

    tag = "R2";
    idle(); drv(0, 1, 1, 0, B0 + 0, 32'hA5); drv(1, 1, 1, 0, B0 + 2, 32'h5A); step();
    idle(); drv(0, 1, 0, 0, B0 + 1, 0); drv(1, 1, 0, 0, B0 + 0, 0); drv(2, 1, 0, 0, B0 + 6, 0); step();

    tag = "R3";
    idle(); drv(0, 1, 1, 2, B0 + 16, 32'hCAFE_F00D); drv(1, 1, 1, 2, B0 + 20, 32'h8765_4321); step();
    idle(); drv(0, 1, 0, 0, B0 + 17, 0); drv(1, 1, 0, 1, B0 + 18, 0); drv(2, 1, 0, 2, B0 + 20, 0); step();
    idle(); drv(0, 1, 0, 0, B0 + 19, 0); drv(2, 1, 0, 1, B0 + 22, 0); step();

    tag = "R4";
    idle(); drv(0, 1, 1, 1, B0 + 32, 32'h1111); drv(1, 1, 1, 1, B0 + 34, 32'h2222);
    drv(2, 1, 1, 2, B0 + 36, 32'h3333_4444); step();
    idle(); drv(0, 1, 0, 2, B0 + 36, 0); drv(1, 1, 0, 2, B0 + 32, 0); step();

    tag = "R5";
    idle(); drv(0, 1, 0, 0, B0 + 40, 0); drv(1, 1, 1, 0, B0 + 41, 32'h99); drv(2, 1, 1, 0, B0 + 40, 32'h88); step();
    idle(); drv(1, 1, 1, 0, B0 + 41, 32'h99); drv(2, 1, 1, 0, B0 + 40, 32'h88); step();
    idle(); drv(2, 1, 1, 0, B0 + 40, 32'h88); step();
    idle(); drv(0, 1, 0, 1, B0 + 40, 0); step();

    tag = "R6";
    idle(); drv(0, 1, 1, 2, B0 + 48, 32'hAAAA_0001); drv(1, 1, 1, 2, B1 + 48, 32'hBBBB_0002); step();
    tag = "R7";
    idle(); drv(2, 1, 0, 2, B1 + 48, 0); drv(0, 1, 0, 1, B0 + 50, 0); step();
    idle(); step();

    tag = "R8";
    idle(); drv(1, 1, 1, 0, B0 + 51, 32'h77); step();
    idle(); drv(0, 1, 0, 2, B0 + 48, 0); step();

    tag = "R9";
    idle(); drv(0, 1, 1, 2, B0 + 2, 32'hFFFF_FFFF); drv(1, 1, 1, 1, B0 + 1, 32'hFFFF); drv(2, 1, 1, 3, B0 + 0, 32'hFFFF_FFFF); step();
    idle(); drv(0, 1, 0, 2, BASE - 4, 0); drv(1, 1, 0, 0, BASE + SPAN, 0); drv(2, 1, 0, 2, B0 + 0, 0); step();

    tag = "R11";
    idle(); drv(0, 1, 1, 1, B0 + 56, 32'h5555); drv(1, 1, 1, 2, B0 + 56, 32'h6666_7777); drv(2, 1, 1, 1, B0 + 58, 32'h8888); step();
    idle(); drv(0, 1, 0, 2, B0 + 56, 0); step();

    tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      for (int r = 0; r < 3; r++) begin
        int s, off;
        logic [31:0] a;
        s   = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
        off = int'($urandom % 32);
        if ($urandom % 5 != 0 && s < 3) off = off & ~((1 << s) - 1);
        a = BASE + 32'(($urandom % 2) << BLK_LG) + 32'(off);
        if ($urandom % 12 == 0) a = BASE + SPAN + 32'(off);
        drv(r, $urandom % 4 != 0, 1'($urandom % 2), s, a, $urandom);
      end
      step();
    end
    idle(); step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule